// File: doc/BRIEF.md
# Soft Ramp Stereo Attenuator

This block scales a stereo stream of signed 24-bit PCM samples by a separate attenuation for each channel. The attenuation is set in 1 dB steps from 0 dB down to 127 dB. Each channel's setting also carries a mute bit. The block does not jump straight to a new setting. It keeps an applied attenuation for each channel and moves it toward the requested one under a choice of policies:
- immediate update,
- one 1 dB step every eight samples (soft ramp),
- changes held until the waveform changes sign (zero cross),
- soft ramp combined with zero cross.

With zero cross on, a timeout keeps a silent or DC input from stalling a change for ever. A single-cycle event input drops both channels to full attenuation. They then climb back to their settings in soft steps, whatever the soft ramp enable says. This is meant for recovery after a disturbance upstream, such as a filter reconfiguration or a clock ratio fault. Samples arrive with a valid strobe, and the scaled samples leave one clock later with their own strobe.

Top module: `softramp_atten`

## Requirements
- R1: For an applied attenuation A (0..127), with q = A/6 and r = A mod 6, the output sample is floor(x * G[r] / 2^(16+q)). G = {65536, 58409, 52057, 46396, 41350, 36854} for r = 0..5, and each entry is round(65536 * 10^(-r/20)).
- R2: `out_valid` is high exactly one clock after each clock on which `in_valid` is high, and low otherwise. The output samples are registered and change only with `out_valid`.
- R3: With `soft_en` and `zc_en` both low, the sample that sees a changed setting is scaled by the old applied value. Every later sample is scaled by the new value.
- R4: With soft stepping active, the applied value moves by exactly 1 toward the target. A move happens on the 8th valid sample counted from the previous move, or from the start of a pending change. It never moves on an earlier sample.
- R5: With `zc_en` high, a move happens only on a valid sample whose sign bit differs from that of the previous valid sample on the same channel, unless R6 applies. In soft mode the R4 interval must also have elapsed.
- R6: With `zc_en` high, a pending move is taken anyway on the 1024th valid sample after the previous move or the start of the change, even if no sign change has occurred.
- R7: The two channels keep separate applied values, counters and sign history. A change on one channel never alters the other channel's output.
- R8: Bit 7 of a channel's 8-bit setting is mute, and bits 6:0 are the attenuation. While mute is set, the target is 127. Once the applied value is 127, the channel outputs 0.
- R9: A high `ramp_evt` forces both applied values to 127 on the next clock. Each channel then soft-steps as in R4 toward its setting until it reaches it, even with `soft_en` low.
- R10: After reset the applied attenuation is 0, `out_valid` is low and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe marking a new stereo sample pair |
| in_l | input | 24 | Left sample, signed |
| in_r | input | 24 | Right sample, signed |
| att_l | input | 8 | Left setting: bit 7 mute, bits 6:0 attenuation in dB |
| att_r | input | 8 | Right setting: bit 7 mute, bits 6:0 attenuation in dB |
| soft_en | input | 1 | Step in 1 dB moves every eight samples |
| zc_en | input | 1 | Hold moves until a sign change, with timeout |
| ramp_evt | input | 1 | Force full attenuation, then soft climb back |
| out_valid | output | 1 | Strobe for the scaled sample pair |
| out_l | output | 24 | Scaled left sample, signed |
| out_r | output | 24 | Scaled right sample, signed |

## Verification
The assertions assume a few things about the inputs. `ramp_evt` is a pulse that is not raised on the same clock as `in_valid`. `soft_en` and `zc_en` change only between samples. The settings may change at any time, because the sequencer reads them only on sample clocks. The bench drives every input on the falling edge. It raises `ramp_evt` only in a clock with no sample and changes the mode enables only between samples. Its sign patterns are held long enough to run the zero-cross timeout all the way to 1024.

// File: rtl/sr_pkg.sv
package sr_pkg;

   localparam int GAIN_FRAC_W = 16;
   localparam int GAIN_W      = GAIN_FRAC_W + 1;
   localparam int STEPS_PER_OCTAVE_SHIFT = 6;

   // Fractional gain for the sub-6 dB remainder, unsigned Q1.16
   function automatic logic [GAIN_W-1:0] frac_gain(input logic [2:0] rem);
      case (rem)
         3'd0:    frac_gain = 17'd65536;
         3'd1:    frac_gain = 17'd58409;
         3'd2:    frac_gain = 17'd52057;
         3'd3:    frac_gain = 17'd46396;
         3'd4:    frac_gain = 17'd41350;
         3'd5:    frac_gain = 17'd36854;
         default: frac_gain = 17'd65536;
      endcase
   endfunction

endpackage

// File: rtl/sr_gain.sv
module sr_gain
   import sr_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int ATT_W  = 7
) (
   input  logic signed [DATA_W-1:0] sample,
   input  logic        [ATT_W-1:0]  att,
   input  logic                     force_zero,
   output logic signed [DATA_W-1:0] scaled
);
   localparam int PROD_W = DATA_W + GAIN_W + 1;

   logic        [ATT_W-1:0]  shift_q;
   logic        [2:0]        rem_r;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] shifted;

   always_comb begin
      shift_q = att / ATT_W'(STEPS_PER_OCTAVE_SHIFT);
      rem_r   = 3'(att % ATT_W'(STEPS_PER_OCTAVE_SHIFT));
      prod    = sample * $signed({1'b0, frac_gain(rem_r)});
      shifted = prod >>> (GAIN_FRAC_W + int'(shift_q));
      scaled  = force_zero ? '0 : shifted[DATA_W-1:0];
   end

endmodule

// File: rtl/sr_stepper.sv
module sr_stepper #(
   parameter int ATT_W        = 7,
   parameter int RAMP_SAMPLES = 8,
   parameter int ZC_TIMEOUT   = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             sign_in,
   input  logic [ATT_W:0]   setting,
   input  logic             soft_en,
   input  logic             zc_en,
   input  logic             ramp_evt,
   output logic [ATT_W-1:0] applied,
   output logic             muted
);
   localparam int CNT_W = $clog2(ZC_TIMEOUT + 1);
   localparam logic [ATT_W-1:0] ATT_MAX  = {ATT_W{1'b1}};
   localparam logic [CNT_W-1:0] RAMP_LIM = CNT_W'(RAMP_SAMPLES - 1);
   localparam logic [CNT_W-1:0] ZC_LIM   = CNT_W'(ZC_TIMEOUT - 1);

   logic [CNT_W-1:0] wait_cnt;
   logic             prev_sign;
   logic             force_r;
   logic [ATT_W-1:0] tgt;
   logic [ATT_W-1:0] nxt;
   logic             step_mode, zc_seen, timer_ok, zc_ok, move;

   always_comb begin
      tgt       = setting[ATT_W] ? ATT_MAX : setting[ATT_W-1:0];
      step_mode = soft_en | force_r;
      zc_seen   = sign_in ^ prev_sign;
      timer_ok  = !step_mode || (wait_cnt >= RAMP_LIM);
      zc_ok     = !zc_en || zc_seen || (wait_cnt >= ZC_LIM);
      move      = (applied != tgt) && timer_ok && zc_ok;
      if (!step_mode)         nxt = tgt;
      else if (applied < tgt) nxt = applied + 1'b1;
      else                    nxt = applied - 1'b1;
      muted     = setting[ATT_W] && (applied == ATT_MAX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         applied   <= '0;
         wait_cnt  <= '0;
         prev_sign <= 1'b0;
         force_r   <= 1'b0;
      end else if (ramp_evt) begin
         applied  <= ATT_MAX;
         force_r  <= 1'b1;
         wait_cnt <= '0;
      end else if (in_valid) begin
         prev_sign <= sign_in;
         if (applied == tgt) begin
            wait_cnt <= '0;
            force_r  <= 1'b0;
         end else if (move) begin
            applied  <= nxt;
            wait_cnt <= '0;
         end else if (wait_cnt < ZC_LIM) begin
            wait_cnt <= wait_cnt + 1'b1;
         end
      end
   end

   // R4: soft moves are single steps
   p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ramp_evt && step_mode) |=>
      (applied == $past(applied) || applied == $past(applied) + 1'b1 ||
       applied + 1'b1 == $past(applied)));

   // R4: no soft move before the interval has elapsed
   p_hold_interval_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ramp_evt && step_mode && wait_cnt < RAMP_LIM) |=> $stable(applied));

   // R5: zero-cross gating holds the value without a sign change
   p_zc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ramp_evt && zc_en && !(sign_in ^ prev_sign) && wait_cnt < ZC_LIM)
      |=> $stable(applied));

   // R6: timeout forces the pending move
   p_zc_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ramp_evt && zc_en && applied != tgt && wait_cnt == ZC_LIM)
      |=> applied != $past(applied));

   // R9: event drops to full attenuation
   p_evt_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_evt |=> applied == ATT_MAX);

endmodule

// File: rtl/sr_channel.sv
module sr_channel #(
   parameter int DATA_W       = 24,
   parameter int ATT_W        = 7,
   parameter int RAMP_SAMPLES = 8,
   parameter int ZC_TIMEOUT   = 1024
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] sample,
   input  logic        [ATT_W:0]    setting,
   input  logic                     soft_en,
   input  logic                     zc_en,
   input  logic                     ramp_evt,
   output logic signed [DATA_W-1:0] out_sample
);
   logic [ATT_W-1:0]         applied;
   logic                     muted;
   logic signed [DATA_W-1:0] scaled;

   sr_stepper #(
      .ATT_W(ATT_W), .RAMP_SAMPLES(RAMP_SAMPLES), .ZC_TIMEOUT(ZC_TIMEOUT)
   ) u_stepper (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .sign_in(sample[DATA_W-1]), .setting(setting),
      .soft_en(soft_en), .zc_en(zc_en), .ramp_evt(ramp_evt),
      .applied(applied), .muted(muted)
   );

   sr_gain #(.DATA_W(DATA_W), .ATT_W(ATT_W)) u_gain (
      .sample(sample), .att(applied), .force_zero(muted), .scaled(scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_sample <= '0;
      else if (in_valid) out_sample <= scaled;
   end

   // R8: a muted channel at full attenuation emits zero
   p_mute_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && muted) |=> out_sample == '0);

endmodule

// File: rtl/softramp_atten.sv
module softramp_atten #(
   parameter int DATA_W       = 24,
   parameter int ATT_W        = 7,
   parameter int RAMP_SAMPLES = 8,
   parameter int ZC_TIMEOUT   = 1024
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_l,
   input  logic signed [DATA_W-1:0] in_r,
   input  logic        [ATT_W:0]    att_l,
   input  logic        [ATT_W:0]    att_r,
   input  logic                     soft_en,
   input  logic                     zc_en,
   input  logic                     ramp_evt,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_l,
   output logic signed [DATA_W-1:0] out_r
);
   localparam int NUM_CH = 2;

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end
   if (ATT_W < 3 || ATT_W > 7) begin : g_bad_att
      $error("ATT_W must be 3..7");
   end
   if (RAMP_SAMPLES < 1) begin : g_bad_ramp
      $error("RAMP_SAMPLES must be at least 1");
   end
   if (ZC_TIMEOUT <= RAMP_SAMPLES) begin : g_bad_tmo
      $error("ZC_TIMEOUT must exceed RAMP_SAMPLES");
   end

   logic signed [DATA_W-1:0] ch_in  [NUM_CH];
   logic        [ATT_W:0]    ch_set [NUM_CH];
   logic signed [DATA_W-1:0] ch_out [NUM_CH];

   always_comb begin
      ch_in[0]  = in_l;
      ch_in[1]  = in_r;
      ch_set[0] = att_l;
      ch_set[1] = att_r;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      sr_channel #(
         .DATA_W(DATA_W), .ATT_W(ATT_W),
         .RAMP_SAMPLES(RAMP_SAMPLES), .ZC_TIMEOUT(ZC_TIMEOUT)
      ) u_ch (
         .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
         .sample(ch_in[c]), .setting(ch_set[c]),
         .soft_en(soft_en), .zc_en(zc_en), .ramp_evt(ramp_evt),
         .out_sample(ch_out[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   assign out_l = ch_out[0];
   assign out_r = ch_out[1];

   // R2: output strobe follows input strobe by one clock
   p_strobe_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_l) && $stable(out_r)));

endmodule

// File: tb/softramp_atten_bench.sv
`timescale 1ns/1ps
module softramp_atten_bench;
   localparam int DW = 24, AW = 7, RS = 8, TMO = 1024;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, in_valid, soft_en, zc_en, ramp_evt, out_valid;
   logic signed [DW-1:0] in_l, in_r, out_l, out_r;
   logic [AW:0] att_l, att_r;

   softramp_atten u_softramp_atten (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
      .att_l(att_l), .att_r(att_r), .soft_en(soft_en), .zc_en(zc_en),
      .ramp_evt(ramp_evt), .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int gtab [6];
   int mcur [2], mcnt [2], mprev [2], mforce [2];

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint model_out(input int c, input longint x, input logic [7:0] s);
      int q, r;
      if (s[7] && mcur[c] == 127) return 0;
      q = mcur[c] / 6;
      r = mcur[c] % 6;
      return (x * gtab[r]) >>> (16 + q);
   endfunction

   task automatic model_step(input int c, input longint x, input logic [7:0] s);
      int tgt, sg;
      bit stepm, zc;
      tgt   = s[7] ? 127 : int'(s[6:0]);
      stepm = soft_en || (mforce[c] != 0);
      sg    = (x < 0) ? 1 : 0;
      zc    = (sg != mprev[c]);
      if (mcur[c] == tgt) begin
         mcnt[c] = 0; mforce[c] = 0;
      end else if ((!stepm || mcnt[c] >= RS-1) && (!zc_en || zc || mcnt[c] >= TMO-1)) begin
         if (!stepm) mcur[c] = tgt;
         else if (mcur[c] < tgt) mcur[c] = mcur[c] + 1;
         else mcur[c] = mcur[c] - 1;
         mcnt[c] = 0;
      end else if (mcnt[c] < TMO-1) mcnt[c]++;
      mprev[c] = sg;
   endtask

   task automatic send(input logic signed [DW-1:0] l, input logic signed [DW-1:0] r,
                       input string tag);
      longint el, er;
      @(negedge clk);
      in_l = l; in_r = r; in_valid = 1'b1;
      el = model_out(0, l, att_l);
      er = model_out(1, r, att_r);
      model_step(0, l, att_l);
      model_step(1, r, att_r);
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " out_valid (R2)"}, longint'(out_valid), 1);
      check({tag, " left"}, longint'(out_l), el);
      check({tag, " right"}, longint'(out_r), er);
   endtask

   task automatic pulse_evt();
      @(negedge clk);
      ramp_evt = 1'b1;
      for (int c = 0; c < 2; c++) begin
         mcur[c] = 127; mforce[c] = 1; mcnt[c] = 0;
      end
      @(negedge clk);
      ramp_evt = 1'b0;
   endtask

   function automatic logic signed [DW-1:0] pat(input int i);
      return DW'(i * 2654435 + 12345);
   endfunction

   function automatic logic signed [DW-1:0] signed_mag(input int i, input bit neg);
      logic signed [DW-1:0] m;
      m = DW'(((i * 7919) % 4000000) + 1000);
      return neg ? -m : m;
   endfunction

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < 6; r++) gtab[r] = int'(65536.0 * (10.0 ** (-real'(r) / 20.0)));
      for (int c = 0; c < 2; c++) begin
         mcur[c] = 0; mcnt[c] = 0; mprev[c] = 0; mforce[c] = 0;
      end
      rst_n = 1'b0; in_valid = 1'b0; in_l = '0; in_r = '0;
      att_l = '0; att_r = '0; soft_en = 1'b0; zc_en = 1'b0; ramp_evt = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 reset out_valid", longint'(out_valid), 0);
      check("R10 reset out_l", longint'(out_l), 0);
      check("R10 reset out_r", longint'(out_r), 0);
      rst_n = 1'b1;
      send(24'sd1000000, -24'sd1000000, "R10 unity gain after reset");

      // R1 / R3: sweep every attenuation, immediate mode
      for (int a = 0; a < 128; a++) begin
         att_l = {1'b0, 7'(a)};
         att_r = {1'b0, 7'(127 - a)};
         send(pat(a), pat(a + 500), "R3 change sample uses old value");
         send(pat(a + 1000), -pat(a + 1000), "R1 gain sweep");
      end
      att_l = 8'd0; att_r = 8'd0;
      send(24'sh7FFFFF, 24'sh800000, "R1 full scale");
      send(24'sh7FFFFF, 24'sh800000, "R1 full scale unity");
      att_l = 8'd13; att_r = 8'd1;
      send(-24'sd1, 24'sd1, "R1 tiny");
      send(-24'sd1, 24'sd1, "R1 tiny floor");
      @(negedge clk);
      check("R2 idle strobe", longint'(out_valid), 0);

      // R4 / R7: soft ramp left down, right steady
      soft_en = 1'b1;
      att_l = 8'd40; att_r = 8'd1;
      for (int i = 0; i < 400; i++) send(pat(i), pat(i + 9), "R4 soft ramp, R7 right steady");
      att_l = 8'd2;
      for (int i = 0; i < 350; i++) send(pat(i + 77), pat(i), "R4 soft ramp up");

      // R5: soft + zero cross, sign flips every few samples
      zc_en = 1'b1;
      att_l = 8'd30; att_r = 8'd10;
      for (int i = 0; i < 600; i++)
         send(signed_mag(i, ((i / 11) % 2) == 1), signed_mag(i + 3, ((i / 5) % 2) == 1),
              "R5 zero cross gating");

      // R6: zero cross alone, no sign change, timeout
      soft_en = 1'b0;
      att_l = 8'd50; att_r = 8'd50;
      for (int i = 0; i < 1030; i++)
         send(signed_mag(i, 1'b0), signed_mag(i, 1'b1), "R6 timeout");
      zc_en = 1'b0;

      // R8: mute with soft ramp to full attenuation then zero
      soft_en = 1'b1;
      att_l = 8'h85; att_r = 8'd7;
      for (int i = 0; i < 700; i++) send(pat(i + 31), pat(i + 5), "R8 mute ramp, R7 independent");
      soft_en = 1'b0;
      att_r = 8'h80;
      send(pat(3), pat(4), "R8 mute immediate");
      send(pat(5), pat(6), "R8 muted zero");
      att_l = 8'd4; att_r = 8'd9;
      send(pat(7), pat(8), "R8 unmute");

      // R9: forced ramp from full attenuation with soft disabled
      send(pat(9), pat(10), "R9 before event");
      pulse_evt();
      for (int i = 0; i < 1050; i++) send(pat(i + 200), pat(i + 300), "R9 forced ramp up");
      att_l = 8'd60;
      send(pat(1), pat(2), "R9 back to immediate");
      send(pat(1), pat(2), "R9 immediate applied");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule